// File: doc/BRIEF.md
# Bfloat16 / Single-Precision Conversion Unit

This unit converts floating-point values in both directions between IEEE single precision (FP32) and bfloat16 (BF16). The direction comes from a select input. The 32-bit operand holds either an FP32 value or a BF16 value NaN-boxed in a 32-bit register. The rounding mode arrives already resolved as a 3-bit code. The result is registered one cycle after the operand is accepted, along with the five accrued exception flags.

Widening copies the BF16 pattern into the top half of an FP32 word, so it is always exact. Narrowing keeps the 8-bit exponent and the top seven fraction bits. It rounds away the low sixteen fraction bits through the same increment logic that an FP32 rounder uses, and a carry out of the fraction ripples into the exponent. A second copy of that increment decision, taken one bit further down, gives tininess after rounding for the underflow flag.

Top module: `bfcvt_unit`

## Requirements
- R1: The result, flags and rm_err appear on the clock edge after in_valid is high, and out_valid is high in that same cycle. While in_valid is low, out_valid is low and result, flags and rm_err keep their values. Reset clears all outputs to zero. The flag bits are: bit 4 invalid, bit 3 divide-by-zero (never set), bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R2: Widening (dir_widen=1) of a properly boxed operand (operand[31:16] all ones) that is not a NaN gives {operand[15:0], 16'h0000}. This covers zeros, subnormals and infinities. It raises no flag, and the rounding-mode input has no effect on it, including illegal codes.
- R3: Widening an operand whose upper 16 bits are not all ones yields the canonical NaN 0x7FC00000 with no flags.
- R4: Widening a BF16 NaN (exponent all ones, nonzero fraction) yields 0x7FC00000. The invalid flag is raised only when the NaN is signalling, that is, when fraction MSB operand[6] is 0.
- R5: Every narrowing result under a legal rounding mode has its upper 16 bits all ones.
- R6: Narrowing (dir_widen=0) drops the 16 low fraction bits and rounds by the rm code: 000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest with ties away. Inexact is set when any dropped bit is nonzero.
- R7: When rounding carries the magnitude past 0x7F7F, the result is signed infinity and overflow and inexact are set. A mode that does not round that value away from zero gives 0x7F7F with the sign, inexact set and no overflow.
- R8: FP32 subnormals narrow into BF16 subnormals. A carry out of the largest subnormal gives the smallest normal, 0x0080.
- R9: Underflow uses tininess after rounding: the value, rounded to 8 significant bits with an unbounded exponent, is below 2^-126. It is raised only together with inexact.
- R10: Narrowing any FP32 NaN gives 0xFFFF7FC0, with invalid raised only for a signalling NaN (operand[22]=0). Infinities and zeros narrow exactly with no flags.
- R11: A narrowing request with rm code 101, 110 or 111 sets rm_err, with result 0 and no flags. Otherwise rm_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand, direction and rounding mode are valid this cycle |
| dir_widen | input | 1 | 1: BF16 to FP32, 0: FP32 to BF16 |
| operand | input | 32 | FP32 value, or BF16 NaN-boxed in 32 bits |
| rm | input | 3 | Resolved rounding mode code |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | FP32 result, or NaN-boxed BF16 result |
| flags | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |
| rm_err | output | 1 | Narrowing was requested with an illegal rounding mode |

## Verification
The assertions assume that dir_widen, operand and rm are fully defined whenever in_valid is high. They also assume the rounding mode has already been resolved, so a dynamic code never reaches the unit except as an illegal value. The bench drives every input to a known value from time zero. It changes inputs only on falling edges and keeps them fixed across each rising edge. Illegal rounding codes are applied on purpose in both directions, so the error path and the "ignored when widening" rule are both exercised within those assumptions.

// File: rtl/bfcvt_pkg.sv
package bfcvt_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FP_FRAC = 23;
    localparam int BF_FRAC = 7;
    localparam int BF_W    = 1 + EXP_W + BF_FRAC;
    localparam int TAIL    = FP_FRAC - BF_FRAC;
    localparam int BOX_W   = FP_W - BF_W;
    localparam int MAG_W   = EXP_W + BF_FRAC;

    localparam logic [2:0] RM_RNE = 3'd0;
    localparam logic [2:0] RM_RTZ = 3'd1;
    localparam logic [2:0] RM_RDN = 3'd2;
    localparam logic [2:0] RM_RUP = 3'd3;
    localparam logic [2:0] RM_RMM = 3'd4;

    localparam logic [FP_W-1:0]  FP_QNAN = 32'h7FC0_0000;
    localparam logic [BF_W-1:0]  BF_QNAN = 16'h7FC0;
    localparam logic [BOX_W-1:0] BOX_ONES = '1;

    typedef struct packed {
        logic nv;
        logic dz;
        logic of;
        logic uf;
        logic nx;
    } flags_t;

    typedef struct packed {
        logic            valid;
        logic [FP_W-1:0] result;
        flags_t          flags;
        logic            rm_err;
    } out_t;

endpackage

// File: rtl/bfcvt_round.sv
module bfcvt_round (
    input  logic       sign,
    input  logic       lsb,
    input  logic       guard,
    input  logic       sticky,
    input  logic [2:0] rm,
    output logic       inc
);
    import bfcvt_pkg::*;

    logic lost;

    always_comb begin
        lost = guard | sticky;
        unique case (rm)
            RM_RNE:  inc = guard & (sticky | lsb);
            RM_RTZ:  inc = 1'b0;
            RM_RDN:  inc = sign & lost;
            RM_RUP:  inc = ~sign & lost;
            RM_RMM:  inc = guard;
            default: inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/bfcvt_widen.sv
module bfcvt_widen (
    input  logic [31:0]       op,
    output logic [31:0]       res,
    output bfcvt_pkg::flags_t flg
);
    import bfcvt_pkg::*;

    logic [BF_W-1:0] half_d;
    logic            boxed_d;
    logic            nan_d;

    always_comb begin
        half_d  = op[BF_W-1:0];
        boxed_d = &op[FP_W-1:BF_W];
        nan_d   = (&half_d[BF_W-2:BF_FRAC]) & (|half_d[BF_FRAC-1:0]);
        flg     = '0;
        if (!boxed_d) begin
            res = FP_QNAN;
        end else if (nan_d) begin
            res    = FP_QNAN;
            flg.nv = ~half_d[BF_FRAC-1];
        end else begin
            res = {half_d, {BOX_W{1'b0}}};
        end
    end

endmodule

// File: rtl/bfcvt_narrow.sv
module bfcvt_narrow (
    input  logic [31:0]       op,
    input  logic [2:0]        rm,
    output logic [15:0]       res,
    output bfcvt_pkg::flags_t flg
);
    import bfcvt_pkg::*;

    logic               sgn;
    logic [EXP_W-1:0]   ex;
    logic [FP_FRAC-1:0] fr;
    logic [MAG_W-1:0]   kept;
    logic [MAG_W-1:0]   sum;
    logic [1:0]         inc_g;
    logic               reach_min;
    logic               tiny;
    logic               lost;

    assign sgn  = op[FP_W-1];
    assign ex   = op[FP_W-2:FP_FRAC];
    assign fr   = op[FP_FRAC-1:0];
    assign kept = {ex, fr[FP_FRAC-1 -: BF_FRAC]};

    // g = 0: rounding at the BF16 LSB; g = 1: one bit finer, for tininess.
    for (genvar g = 0; g < 2; g++) begin : g_rnd
        localparam int LSB = TAIL - g;
        bfcvt_round u_round (
            .sign   (sgn),
            .lsb    (fr[LSB]),
            .guard  (fr[LSB-1]),
            .sticky (|fr[LSB-2:0]),
            .rm     (rm),
            .inc    (inc_g[g])
        );
    end

    always_comb begin
        sum       = kept + MAG_W'(inc_g[0]);
        lost      = fr[TAIL-1] | (|fr[TAIL-2:0]);
        reach_min = (&fr[FP_FRAC-1:TAIL-1]) & inc_g[1];
        tiny      = (ex == '0) & ~reach_min;
        flg       = '0;
        if (&ex) begin
            if (fr != '0) begin
                res    = BF_QNAN;
                flg.nv = ~fr[FP_FRAC-1];
            end else begin
                res = {sgn, ex, {BF_FRAC{1'b0}}};
            end
        end else begin
            res    = {sgn, sum};
            flg.nx = lost;
            flg.of = &sum[MAG_W-1:BF_FRAC];
            flg.uf = tiny & lost;
        end
    end

endmodule

// File: rtl/bfcvt_unit.sv
module bfcvt_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        dir_widen,
    input  logic [31:0] operand,
    input  logic [2:0]  rm,
    output logic        out_valid,
    output logic [31:0] result,
    output logic [4:0]  flags,
    output logic        rm_err
);
    import bfcvt_pkg::*;

    logic [FP_W-1:0] w_res;
    flags_t          w_flg;
    logic [BF_W-1:0] n_res;
    flags_t          n_flg;
    logic            rm_bad;
    out_t            st_d;
    out_t            st_q;

    bfcvt_widen u_widen (
        .op  (operand),
        .res (w_res),
        .flg (w_flg)
    );

    bfcvt_narrow u_narrow (
        .op  (operand),
        .rm  (rm),
        .res (n_res),
        .flg (n_flg)
    );

    always_comb begin
        rm_bad      = rm > RM_RMM;
        st_d        = st_q;
        st_d.valid  = in_valid;
        if (in_valid) begin
            if (dir_widen) begin
                st_d.result = w_res;
                st_d.flags  = w_flg;
                st_d.rm_err = 1'b0;
            end else if (rm_bad) begin
                st_d.result = '0;
                st_d.flags  = '0;
                st_d.rm_err = 1'b1;
            end else begin
                st_d.result = {BOX_ONES, n_res};
                st_d.flags  = n_flg;
                st_d.rm_err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign flags     = st_q.flags;
    assign rm_err    = st_q.rm_err;

endmodule

// File: rtl/bfcvt_unit_chk.sv
module bfcvt_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        dir_widen,
    input logic [31:0] operand,
    input logic [2:0]  rm,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [4:0]  flags,
    input logic        rm_err
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags) && $stable(rm_err)));

    p_widen_no_round_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_widen) |=> (flags[3:0] == 4'b0 && !rm_err));

    p_widen_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_widen && (&operand[31:16]) && operand[14:7] != 8'hFF)
        |=> result == {$past(operand[15:0]), 16'h0000});

    p_narrow_boxed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_widen && rm <= 3'd4) |=> result[31:16] == 16'hFFFF);

    p_overflow_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[2]) |-> flags[0]);

    p_underflow_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[1]) |-> flags[0]);

    p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_widen && rm > 3'd4) |=> (rm_err && result == 32'h0 && flags == 5'h0));

endmodule

bind bfcvt_unit bfcvt_unit_chk u_chk (.*);

// File: tb/bfcvt_unit_bench.sv
`timescale 1ns/1ps
module bfcvt_unit_bench;

    localparam real CLK_NS = 4.0;

    typedef struct {
        bit        v;
        bit [31:0] r;
        bit [4:0]  f;
        bit        e;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir_widen = 1'b0;
    logic [31:0] operand = 32'h0;
    logic [2:0]  rm = 3'd0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  flags;
    logic        rm_err;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t pend[$];
    exp_t last;

    always #(CLK_NS / 2.0) clk = ~clk;

    bfcvt_unit u_bfcvt_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .dir_widen (dir_widen),
        .operand   (operand),
        .rm        (rm),
        .out_valid (out_valid),
        .result    (result),
        .flags     (flags),
        .rm_err    (rm_err)
    );

    function automatic bit round_up(bit s, int lsb, int rem, int half, bit [2:0] mode);
        case (mode)
            3'd0:    return (rem > half) || (rem == half && lsb != 0);
            3'd2:    return s && rem != 0;
            3'd3:    return !s && rem != 0;
            3'd4:    return rem >= half;
            default: return 1'b0;
        endcase
    endfunction

    function automatic exp_t model(bit d, bit [31:0] op, bit [2:0] mode);
        exp_t x;
        int   mag, q, rem, qr, q2, rem2;
        bit   s;
        x.v = 1'b1; x.f = 5'h0; x.e = 1'b0;
        if (d) begin
            if (op[31:16] != 16'hFFFF) x.r = 32'h7FC00000;
            else if (op[14:7] == 8'hFF && op[6:0] != 7'h0) begin
                x.r = 32'h7FC00000;
                x.f = op[6] ? 5'h00 : 5'h10;
            end else x.r = {op[15:0], 16'h0};
        end else if (mode > 3'd4) begin
            x.r = 32'h0; x.e = 1'b1;
        end else begin
            s   = op[31];
            mag = int'({1'b0, op[30:0]});
            if (op[30:23] == 8'hFF) begin
                if (op[22:0] != 23'h0) begin
                    x.r = 32'hFFFF7FC0;
                    x.f = op[22] ? 5'h00 : 5'h10;
                end else x.r = {16'hFFFF, op[31:16]};
            end else begin
                q   = mag / 65536;
                rem = mag % 65536;
                qr  = q + int'(round_up(s, q % 2, rem, 32768, mode));
                x.r = {16'hFFFF, s, 15'(qr)};
                if (rem != 0) x.f[0] = 1'b1;
                if (qr >= 32'h7F80) x.f[2] = 1'b1;
                if (mag < 32'h0080_0000) begin
                    q2   = mag / 32768;
                    rem2 = mag % 32768;
                    q2   = q2 + int'(round_up(s, q2 % 2, rem2, 16384, mode));
                    if (q2 * 32768 < 32'h0080_0000 && rem != 0) x.f[1] = 1'b1;
                end
            end
        end
        return x;
    endfunction

    task automatic compare(exp_t x, string tag);
        n_vec++;
        if (out_valid !== x.v || result !== x.r || flags !== x.f || rm_err !== x.e) begin
            n_bad++;
            $display("FAIL %s: got v=%0b r=%08h f=%05b e=%0b, expected v=%0b r=%08h f=%05b e=%0b",
                     tag, out_valid, result, flags, rm_err, x.v, x.r, x.f, x.e);
        end
        last = x;
    endtask

    task automatic apply(bit d, bit [31:0] op, bit [2:0] mode, string tag);
        in_valid  = 1'b1;
        dir_widen = d;
        operand   = op;
        rm        = mode;
        pend.push_back(model(d, op, mode));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        compare(pend.pop_front(), tag);
    endtask

    task automatic idle(string tag);
        exp_t x;
        x   = last;
        x.v = 1'b0;
        in_valid = 1'b0;
        operand  = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        compare(x, tag);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        exp_t z;
        bit [31:0] lcg;
        z.v = 0; z.r = 0; z.f = 0; z.e = 0;
        repeat (3) @(negedge clk);
        compare(z, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 widening exact, rm ignored even if illegal
        apply(1, 32'hFFFF_3F80, 3'd0, "R2 widen one");
        apply(1, 32'hFFFF_3F80, 3'd7, "R2 widen rm ignored");
        apply(1, 32'hFFFF_FF80, 3'd5, "R2 widen -inf");
        apply(1, 32'hFFFF_8000, 3'd1, "R2 widen -zero");
        apply(1, 32'hFFFF_0001, 3'd0, "R8 widen subnormal");
        idle("R1 hold");
        idle("R1 hold twice");
        // R3 unboxed
        apply(1, 32'h0000_3F80, 3'd0, "R3 unboxed");
        apply(1, 32'hFFFE_7F81, 3'd0, "R3 unboxed nan");
        // R4 widening NaN
        apply(1, 32'hFFFF_7F81, 3'd0, "R4 widen snan");
        apply(1, 32'hFFFF_FFC1, 3'd0, "R4 widen qnan");
        // R5/R6 narrowing and rounding modes
        apply(0, 32'h3F80_0000, 3'd0, "R5 narrow one");
        apply(0, 32'h3F80_8000, 3'd0, "R6 rne tie even");
        apply(0, 32'h3F81_8000, 3'd0, "R6 rne tie odd");
        apply(0, 32'h3F80_8000, 3'd4, "R6 rmm tie");
        apply(0, 32'h3F80_FFFF, 3'd1, "R6 rtz");
        apply(0, 32'h3F80_0001, 3'd3, "R6 rup pos");
        apply(0, 32'h3F80_0001, 3'd2, "R6 rdn pos");
        apply(0, 32'hBF80_0001, 3'd2, "R6 rdn neg");
        apply(0, 32'hBF80_0001, 3'd3, "R6 rup neg");
        // R7 overflow
        apply(0, 32'h7F7F_8000, 3'd0, "R7 rne overflow");
        apply(0, 32'h7F7F_FFFF, 3'd1, "R7 rtz saturate");
        apply(0, 32'hFF7F_FFFF, 3'd2, "R7 rdn neg overflow");
        apply(0, 32'hFF7F_FFFF, 3'd3, "R7 rup neg saturate");
        // R8/R9 subnormals and underflow
        apply(0, 32'h0001_0000, 3'd0, "R8 exact subnormal");
        apply(0, 32'h0001_8000, 3'd0, "R9 subnormal inexact");
        apply(0, 32'h007F_8000, 3'd0, "R9 tiny after rounding");
        apply(0, 32'h007F_C000, 3'd0, "R9 rounds to min normal");
        apply(0, 32'h007F_FFFF, 3'd1, "R8 rtz largest subnormal");
        apply(0, 32'h8000_0001, 3'd2, "R9 neg tiny rdn");
        // R10 specials
        apply(0, 32'h7F80_0001, 3'd0, "R10 narrow snan");
        apply(0, 32'hFFC1_2345, 3'd0, "R10 narrow qnan");
        apply(0, 32'h7F80_0000, 3'd3, "R10 narrow inf");
        apply(0, 32'h8000_0000, 3'd0, "R10 narrow -zero");
        // R11 illegal modes
        apply(0, 32'h3F80_0001, 3'd5, "R11 rm 101");
        apply(0, 32'h3F80_0001, 3'd6, "R11 rm 110");
        apply(0, 32'h4000_0000, 3'd7, "R11 rm 111");
        idle("R1 hold after error");
        // sweep
        lcg = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            if (i % 7 == 0) apply(1, {16'hFFFF, lcg[23:8]}, 3'(i % 8), "R2 sweep widen");
            else if (i % 11 == 0) apply(0, {lcg[31], 8'h00, lcg[22:0]}, 3'(i % 5), "R8 sweep subnormal");
            else apply(0, lcg, 3'(i % 5), "R6 sweep narrow");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule